// File: doc/BRIEF.md
# Sample Output Pipeline with Aligned Pre-Blanking

This block is the last digital stage of a converter data path. Each 14-bit sample presented at its input is carried through a fixed seven-stage pipeline. A 2-bit setting can lengthen that pipeline by zero to three more cycles, and the result leaves through an output register on the rising clock edge.

Two controls force the output word to zero. An active-low blanking request travels down its own one-bit pipeline, so that the zeroing lands on a fixed clock edge, nine edges after the request is first seen. That count does not depend on the extra-delay setting. A power-save bit clears the pipeline and the output at once. Changing the extra-delay setting also flushes the pipeline, so that no sample is repeated or lost across the change in latency.

The asynchronous reset input is released through an internal two-flop synchronizer. All timing below counts rising edges at which the synchronized reset is inactive.

Top module: `sample_out_pipe`

## Requirements
- R1: While reset is asserted the output is zero, and every stage holds zero, so the output stays zero until a sample captured after reset reaches it.
- R2: With the extra-delay setting at 0, a sample captured on edge n appears on `dout` just after edge n+6, which is seven edges counting the capturing one.
- R3: The extra-delay setting `xdly` is an unsigned 2-bit count x (0 to 3). It moves the appearance of a sample captured on edge n to just after edge n+6+x.
- R4: If `blank_n` is sampled low on edge m, `dout` is all zeros just after edge m+8, which is the ninth edge counting m. This holds for every such edge, whatever the extra-delay setting.
- R5: An output edge whose blanking sample eight edges earlier was high carries the full pipelined data word, so blanking ends on the same nine-edge alignment with no partial words.
- R6: If `psave` is sampled high on an edge, `dout` is zero just after that edge, and a sample captured on such an edge never reaches the output.
- R7: If `xdly` differs on an edge from its value on the previous edge, all data stages and the output clear on that edge. Only samples captured on later edges appear afterwards, at the new latency.
- R8: When blanking and a clear (power save or delay change) fall on the same output edge, that word is zero. Data resumes only when both conditions have ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 14 | Incoming sample word |
| blank_n | input | 1 | Active-low pre-blanking request |
| psave | input | 1 | Power-save: clear pipeline and force output to zero |
| xdly | input | 2 | Extra output latency in cycles (0 to 3) |
| dout | output | 14 | Delayed sample word, or zero when blanked or cleared |

## Verification
Blanking zeroes a word through its own nine-edge flag chain. A power-save pulse or a delay change zeroes through an immediate clear of the data stages. The two can land on the same output edge. The bench forces this by raising `psave`, or by changing `xdly`, exactly eight edges after `blank_n` falls, and again on the very edge that `blank_n` falls. A scoreboard model works out, for each edge, which captured sample is due and whether a clear or a blanking sample eight edges back overrides it. Agreement is required both on the coinciding zero word and on the first non-zero word after both conditions have ended.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned SOP_DW        = 14;
  localparam int unsigned SOP_BASE_LAT  = 7;
  localparam int unsigned SOP_BLANK_LAT = 9;
  localparam int unsigned SOP_XW        = 2;

  function automatic int unsigned sop_data_stages(input int unsigned base_lat,
                                                  input int unsigned xw);
    return (base_lat - 1) + ((1 << xw) - 1);
  endfunction
endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_nxt;
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/sop_shift.sv
module sop_shift #(
  parameter int unsigned W     = 14,
  parameter int unsigned DEPTH = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic [W-1:0]               d,
  output logic [DEPTH-1:0][W-1:0]    q
);
  logic [W-1:0]            stg_in [DEPTH];
  logic [DEPTH-1:0][W-1:0] q_nxt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stg
    if (g == 0) begin : g_head
      assign stg_in[g] = d;
    end else begin : g_body
      assign stg_in[g] = q[g-1];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      q_nxt[i] = clr ? '0 : stg_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/sop_cfg_track.sv
module sop_cfg_track #(
  parameter int unsigned XW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] xdly,
  output logic [XW-1:0] cfg_q,
  output logic          cfg_chg
);
  logic [XW-1:0] cfg_nxt;

  always_comb begin
    cfg_nxt = xdly;
    cfg_chg = (xdly != cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_nxt;
  end
endmodule

// File: rtl/sop_out_stage.sv
module sop_out_stage #(
  parameter int unsigned DW       = 14,
  parameter int unsigned XW       = 2,
  parameter int unsigned TAP0     = 5,
  parameter int unsigned DEPTH    = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      blank_hit,
  input  logic [DEPTH-1:0][DW-1:0]  stages,
  input  logic [XW-1:0]             cfg,
  output logic [DW-1:0]             dout
);
  logic [DW-1:0] tap;
  logic [DW-1:0] dout_nxt;
  logic          zero_en;

  always_comb begin
    tap = stages[TAP0 + int'(cfg)];
  end

  always_comb begin
    zero_en  = clr | blank_hit;
    dout_nxt = zero_en ? '0 : tap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= dout_nxt;
  end
endmodule

// File: rtl/sample_out_pipe.sv
module sample_out_pipe #(
  parameter int unsigned DW        = sop_pkg::SOP_DW,
  parameter int unsigned BASE_LAT  = sop_pkg::SOP_BASE_LAT,
  parameter int unsigned BLANK_LAT = sop_pkg::SOP_BLANK_LAT,
  parameter int unsigned XW        = sop_pkg::SOP_XW
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [DW-1:0] din,
  input  logic          blank_n,
  input  logic          psave,
  input  logic [XW-1:0] xdly,
  output logic [DW-1:0] dout
);
  localparam int unsigned DSTAGES = sop_pkg::sop_data_stages(BASE_LAT, XW);
  localparam int unsigned BSTAGES = BLANK_LAT - 1;
  localparam int unsigned TAP0    = BASE_LAT - 2;

  logic                         rst_n_s;
  logic [XW-1:0]                cfg_q;
  logic                         cfg_chg;
  logic                         clr;
  logic [DSTAGES-1:0][DW-1:0]   data_q;
  logic [BSTAGES-1:0][0:0]      bl_q;
  logic                         blank_req;
  logic                         blank_hit;

  sop_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_s (rst_n_s)
  );

  sop_cfg_track #(.XW(XW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .xdly    (xdly),
    .cfg_q   (cfg_q),
    .cfg_chg (cfg_chg)
  );

  assign clr       = psave | cfg_chg;
  assign blank_req = ~blank_n;
  assign blank_hit = bl_q[BSTAGES-1][0];

  sop_shift #(.W(DW), .DEPTH(DSTAGES)) u_data (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (clr),
    .d     (din),
    .q     (data_q)
  );

  sop_shift #(.W(1), .DEPTH(BSTAGES)) u_blank (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (1'b0),
    .d     (blank_req),
    .q     (bl_q)
  );

  sop_out_stage #(.DW(DW), .XW(XW), .TAP0(TAP0), .DEPTH(DSTAGES)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (clr),
    .blank_hit (blank_hit),
    .stages    (data_q),
    .cfg       (cfg_q),
    .dout      (dout)
  );
endmodule

// File: rtl/sop_chk.sv
module sop_chk #(
  parameter int unsigned DW = 14,
  parameter int unsigned XW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blank_n,
  input logic          psave,
  input logic [XW-1:0] xdly,
  input logic [XW-1:0] cfg_q,
  input logic          cfg_chg,
  input logic          bl_first,
  input logic          blank_hit,
  input logic [DW-1:0] dout
);
  AST_PSAVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    psave |=> (dout == '0)); // R6

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    blank_hit |=> (dout == '0)); // R4

  AST_BLANK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> bl_first); // R4

  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (dout == '0)); // R7

  AST_CFG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (cfg_q == $past(xdly))); // R3

  AST_BOTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_hit && (psave || cfg_chg)) |=> (dout == '0)); // R8
endmodule

bind sample_out_pipe sop_chk #(.DW(DW), .XW(XW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .blank_n   (blank_n),
  .psave     (psave),
  .xdly      (xdly),
  .cfg_q     (cfg_q),
  .cfg_chg   (cfg_chg),
  .bl_first  (bl_q[0][0]),
  .blank_hit (blank_hit),
  .dout      (dout)
);

// File: tb/sample_out_pipe_tb.sv
`timescale 1ns/1ps
module sample_out_pipe_tb;
  localparam int DW  = 14;
  localparam int LAT = 7;
  localparam int BLK = 9;
  localparam int HMAX = 1024;

  logic          clk;
  logic          arst_n;
  logic [DW-1:0] din;
  logic          blank_n;
  logic          psave;
  logic [1:0]    xdly;
  logic [DW-1:0] dout;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t         sb_q[$];
  logic [DW-1:0] din_h [HMAX];
  bit            bn_h  [HMAX];
  int            e_cnt;
  int            cfg_m;
  int            last_clr;
  int            n_chk;
  int            n_bad;
  bit            done;

  sample_out_pipe u_dut (
    .clk     (clk),
    .arst_n  (arst_n),
    .din     (din),
    .blank_n (blank_n),
    .psave   (psave),
    .xdly    (xdly),
    .dout    (dout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step(input logic [DW-1:0] d, input bit bn, input bit ps,
                      input int xd, input string tag);
    item_t it;
    int    src;
    bit    clr;
    @(negedge clk);
    din     = d;
    blank_n = bn;
    psave   = ps;
    xdly    = 2'(xd);
    din_h[e_cnt] = d;
    bn_h[e_cnt]  = bn;
    clr   = ps || (xd != cfg_m);
    cfg_m = xd;
    it.tag = tag;
    if (clr) begin
      last_clr = e_cnt;
      it.exp   = '0;
    end else begin
      src = e_cnt - (LAT - 1) - cfg_m;
      if (src < 0) begin
        it.exp = '0;
        it.tag = "R1";
      end else if (src <= last_clr) begin
        it.exp = '0;
      end else begin
        it.exp = din_h[src];
      end
    end
    if (e_cnt >= BLK - 1 && !bn_h[e_cnt - (BLK - 1)]) begin
      it.exp = '0;
      if (!clr) it.tag = (tag == "R8") ? "R8" : "R4";
    end
    sb_q.push_back(it);
    e_cnt++;
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom_range(1, (1 << DW) - 1));
  endfunction

  // monitor: compare after each edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_chk++;
        if (dout !== it.exp) begin
          n_bad++;
          $display("FAIL %s: dout=%h expected=%h at t=%0t", it.tag, dout, it.exp, $time);
        end
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    e_cnt = 0; cfg_m = 0; last_clr = -1;
    arst_n = 1'b0; din = '0; blank_n = 1'b1; psave = 1'b0; xdly = 2'd0;
    // R1: output zero during reset
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      n_chk++;
      if (dout !== '0) begin
        n_bad++;
        $display("FAIL R1: dout=%h expected=%h in reset", dout, {DW{1'b0}});
      end
    end
    @(negedge clk) arst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: base latency
    for (int i = 0; i < 40; i++) step(rnd(), 1'b1, 1'b0, 0, "R2");
    // R3 / R7: each extra delay, flush on change
    for (int x = 1; x < 4; x++) begin
      step(rnd(), 1'b1, 1'b0, x, "R7");
      for (int i = 0; i < 30; i++) step(rnd(), 1'b1, 1'b0, x, "R3");
    end
    step(rnd(), 1'b1, 1'b0, 1, "R7");
    for (int i = 0; i < 20; i++) step(rnd(), 1'b1, 1'b0, 1, "R7");
    // R4 / R5: blank pulses of several widths at two delays
    for (int x = 0; x < 3; x += 2) begin
      for (int i = 0; i < 12; i++) step(rnd(), 1'b1, 1'b0, x, "R5");
      step(rnd(), 1'b0, 1'b0, x, "R5");
      for (int i = 0; i < 12; i++) step(rnd(), 1'b1, 1'b0, x, "R5");
      for (int i = 0; i < 5; i++)  step(rnd(), 1'b0, 1'b0, x, "R5");
      for (int i = 0; i < 14; i++) step(rnd(), 1'b1, 1'b0, x, "R5");
    end
    // R6: power-save pulses
    for (int i = 0; i < 3; i++)  step(rnd(), 1'b1, 1'b1, 2, "R6");
    for (int i = 0; i < 14; i++) step(rnd(), 1'b1, 1'b0, 2, "R6");
    step(rnd(), 1'b1, 1'b1, 2, "R6");
    for (int i = 0; i < 14; i++) step(rnd(), 1'b1, 1'b0, 2, "R6");
    // R8: blank landing on a psave edge, then blank on a delay-change edge
    step(rnd(), 1'b0, 1'b0, 2, "R8");
    for (int i = 0; i < 7; i++) step(rnd(), 1'b1, 1'b0, 2, "R8");
    step(rnd(), 1'b1, 1'b1, 2, "R8");
    for (int i = 0; i < 14; i++) step(rnd(), 1'b1, 1'b0, 2, "R8");
    step(rnd(), 1'b0, 1'b0, 0, "R8");
    for (int i = 0; i < 3; i++) step(rnd(), 1'b0, 1'b0, 0, "R8");
    for (int i = 0; i < 16; i++) step(rnd(), 1'b1, 1'b0, 0, "R8");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule